// File: doc/BRIEF.md
# AGC Pulse-Width Control Output

This block turns an 8-bit gain-control word into a slow pulse-width-modulated line that steers a tuner or IF amplifier. The line is open-drain. It is modelled as a single pull-low enable, and an external pull-up and a single-pole RC network turn it into a control voltage. A receiver holds two copies of the block, one for the tuner gain and one for the IF gain.

The automatically computed gain word is sampled only once per 1024 received symbols, counted on a symbol strobe. A PWM period is 256 slow ticks, and one tick occurs every 16 system clocks. The value that sets the duty is latched only at the wrap of a period, so every period is a single clean low pulse followed by release. A mode input can replace the automatic value with a fixed duty written by the host. A change of mode, or of the host duty, also waits for the next period boundary.

Top module: `agc_pwm_gen`

## Requirements
- R1: After reset the active duty and the stored automatic value are both 128. The output pulls low from the first cycle after reset for 128 ticks (2048 clocks) of the first period.
- R2: The period counter advances exactly once every 16 system clocks. The output level changes only in the cycle after such a tick.
- R3: With active duty D (0..255), each 4096-clock period starts with the line pulled low (`pwm_pull_low` = 1) for D ticks (16·D clocks), then releases it for the rest of the period. D = 0 never pulls low. D = 255 releases the line only during the last tick.
- R4: The automatic value is captured from `agc_level` only on the 1024th symbol strobe since the previous capture (or since reset). Changes of `agc_level` with fewer strobes have no effect on the output.
- R5: The active duty changes only at the wrap of the period counter from 255 to 0. A new value taken mid-period shows only from the next period.
- R6: With `use_host_duty` = 1 at a period boundary, the next period uses `host_duty`. With 0, it uses the stored automatic value. Toggling the mode mid-period has no effect until the boundary.
- R7: Symbol strobes keep updating the stored automatic value while host mode is selected. Returning to automatic mode uses the most recent capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | One-cycle pulse per received symbol |
| agc_level | input | 8 | Gain word from the AGC loop |
| use_host_duty | input | 1 | 1 selects the host duty, 0 the automatic value |
| host_duty | input | 8 | Fixed duty written by the host |
| pwm_pull_low | output | 1 | 1 = drive the open-drain line low, 0 = release |

## Verification
The hardest case to reach from the ports is the exact symbol-count edge. The bench first gives 1023 strobes and shows that the captured value has not moved, then gives the single 1024th strobe and shows that the value lands one period later. It also changes the mode and the host duty in the middle of a period. It then measures the whole low time of that period and of the next one, which shows that nothing reaches the line before the period wrap. Duty values 0 and 255 are driven through host mode to exercise the pulse shape at both ends.

// File: rtl/agc_pwm_pkg.sv
package agc_pwm_pkg;

    localparam int DUTY_W       = 8;
    localparam int TICK_DIV_DEF = 16;
    localparam int REFRESH_DEF  = 1024;
    localparam int RESET_DUTY   = 1 << (DUTY_W - 1);

    typedef logic [DUTY_W-1:0] duty_t;

    typedef enum logic {
        SRC_LOOP = 1'b0,
        SRC_HOST = 1'b1
    } duty_src_e;

    typedef struct packed {
        duty_src_e src;
        duty_t     value;
    } duty_req_t;

    function automatic duty_req_t pick_request(logic host_sel, duty_t loop_v, duty_t host_v);
        duty_req_t r;
        r.src   = host_sel ? SRC_HOST : SRC_LOOP;
        r.value = host_sel ? host_v : loop_v;
        return r;
    endfunction

endpackage

// File: rtl/agc_pwm_tick_div.sv
module agc_pwm_tick_div #(
    parameter int DIV = agc_pwm_pkg::TICK_DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/agc_pwm_refresh.sv
module agc_pwm_refresh
    import agc_pwm_pkg::*;
#(
    parameter int SYMS = REFRESH_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sym_stb,
    input  duty_t agc_level,
    output logic  refresh,
    output duty_t staged
);
    localparam int SW = (SYMS > 1) ? $clog2(SYMS) : 1;

    logic [SW-1:0] sym_cnt_q;

    assign refresh = sym_stb && (sym_cnt_q == SW'(SYMS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_cnt_q <= '0;
            staged    <= duty_t'(RESET_DUTY);
        end else if (sym_stb) begin
            if (refresh) begin
                sym_cnt_q <= '0;
                staged    <= agc_level;
            end else begin
                sym_cnt_q <= sym_cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/agc_pwm_core.sv
module agc_pwm_core
    import agc_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  duty_t loop_duty,
    input  logic  host_sel,
    input  duty_t host_duty,
    output logic  boundary,
    output duty_t period_cnt,
    output duty_t active_duty,
    output logic  pull_low
);
    duty_req_t active_q;

    assign boundary    = tick && (period_cnt == '1);
    assign active_duty = active_q.value;
    assign pull_low    = (period_cnt < active_q.value);

    always_ff @(posedge clk) begin
        if (rst) begin
            period_cnt     <= '0;
            active_q.src   <= SRC_LOOP;
            active_q.value <= duty_t'(RESET_DUTY);
        end else if (tick) begin
            period_cnt <= period_cnt + 1'b1;
            if (boundary) begin
                active_q <= pick_request(host_sel, loop_duty, host_duty);
            end
        end
    end
endmodule

// File: rtl/agc_pwm_gen.sv
module agc_pwm_gen
    import agc_pwm_pkg::*;
#(
    parameter int TICK_DIV = TICK_DIV_DEF,
    parameter int REFRESH  = REFRESH_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sym_stb,
    input  logic [DUTY_W-1:0]   agc_level,
    input  logic                use_host_duty,
    input  logic [DUTY_W-1:0]   host_duty,
    output logic                pwm_pull_low
);
    logic  tick;
    logic  refresh;
    logic  boundary;
    duty_t staged;
    duty_t period_cnt;
    duty_t active_duty;

    agc_pwm_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    agc_pwm_refresh #(.SYMS(REFRESH)) u_refresh (
        .clk       (clk),
        .rst       (rst),
        .sym_stb   (sym_stb),
        .agc_level (agc_level),
        .refresh   (refresh),
        .staged    (staged)
    );

    agc_pwm_core u_core (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .loop_duty   (staged),
        .host_sel    (use_host_duty),
        .host_duty   (host_duty),
        .boundary    (boundary),
        .period_cnt  (period_cnt),
        .active_duty (active_duty),
        .pull_low    (pwm_pull_low)
    );
endmodule

// File: rtl/agc_pwm_chk.sv
module agc_pwm_chk
    import agc_pwm_pkg::*;
#(
    parameter int TICK_DIV = TICK_DIV_DEF
) (
    input logic  clk,
    input logic  rst,
    input logic  tick,
    input logic  refresh,
    input logic  boundary,
    input duty_t agc_level,
    input duty_t staged,
    input duty_t period_cnt,
    input duty_t active_duty,
    input logic  pwm_pull_low
);
    localparam int GW = (TICK_DIV > 1) ? $clog2(TICK_DIV) + 1 : 2;

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)       gap_q <= '0;
        else if (tick) gap_q <= '0;
        else           gap_q <= gap_q + 1'b1;
    end

    // R2: ticks exactly TICK_DIV clocks apart
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |-> gap_q == GW'(TICK_DIV - 1));

    // R2: the line moves only after a tick
    p_out_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(pwm_pull_low) |-> $past(tick));

    // R3: zero duty never pulls the line low
    p_zero_duty_r3: assert property (@(posedge clk) disable iff (rst)
        (active_duty == '0) |-> !pwm_pull_low);

    // R3: the last tick of every period is released
    p_last_release_r3: assert property (@(posedge clk) disable iff (rst)
        (period_cnt == '1) |-> !pwm_pull_low);

    // R4: capture of the loop value on refresh
    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        refresh |=> staged == $past(agc_level));

    // R4: stored value holds between refreshes
    p_stage_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !refresh |=> $stable(staged));

    // R5: active duty changes only at the period wrap
    p_duty_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(active_duty));

    // R5: the wrap restarts the period count
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        boundary |=> period_cnt == '0);
endmodule

bind agc_pwm_gen agc_pwm_chk #(.TICK_DIV(TICK_DIV)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .refresh      (refresh),
    .boundary     (boundary),
    .agc_level    (agc_level),
    .staged       (staged),
    .period_cnt   (period_cnt),
    .active_duty  (active_duty),
    .pwm_pull_low (pwm_pull_low)
);

// File: tb/agc_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module agc_pwm_gen_tb_top;

    localparam int PERIOD_CLKS = 4096;
    localparam int TICK_CLKS   = 16;
    localparam int N_WIN       = 12;

    typedef struct {
        int    duty;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_stb = 1'b0;
    logic [7:0] agc_level = 8'h00;
    logic       use_host_duty = 1'b0;
    logic [7:0] host_duty = 8'h00;
    logic       pwm_pull_low;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   reported = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    agc_pwm_gen dut_i (
        .clk           (clk),
        .rst           (rst),
        .sym_stb       (sym_stb),
        .agc_level     (agc_level),
        .use_host_duty (use_host_duty),
        .host_duty     (host_duty),
        .pwm_pull_low  (pwm_pull_low)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int duty, input string tag);
        exp_t e;
        e.duty = duty;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic wait_cyc(input int k);
        do begin
            @(posedge clk);
            #1;
        end while (cyc < k);
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            sym_stb = 1'b1;
            @(posedge clk);
            #1;
        end
        sym_stb = 1'b0;
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    // monitor: measures each period and compares with the scoreboard
    int   low_cnt = 0;
    int   falls = 0;
    logic start_lvl = 1'b0;
    logic prev_lvl = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            int off;
            off = cyc % PERIOD_CLKS;
            if (cyc == 0)
                check(pwm_pull_low == 1'b1, "R1", "reset level", pwm_pull_low, 1);
            if (off == 0) begin
                low_cnt   = 0;
                falls     = 0;
                start_lvl = pwm_pull_low;
            end else if (prev_lvl && !pwm_pull_low) begin
                falls++;
            end
            if (pwm_pull_low) low_cnt++;
            prev_lvl = pwm_pull_low;
            if (off == PERIOD_CLKS - 1) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3", "scoreboard empty", 0, 1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(low_cnt == e.duty * TICK_CLKS, e.tag, "low clocks",
                          low_cnt, e.duty * TICK_CLKS);
                    check(int'(start_lvl) == int'(e.duty != 0), "R3", "start level",
                          start_lvl, int'(e.duty != 0));
                    check(falls == int'(e.duty != 0), "R3", "release edges",
                          falls, int'(e.duty != 0));
                    check(pwm_pull_low == 1'b0, "R3", "last tick released",
                          pwm_pull_low, 0);
                end
            end
        end
    end

    // driver
    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        push(128, "R1");                       // window 0: reset duty
        wait_cyc(100);
        agc_level = 8'h40;                     // no strobes yet
        push(128, "R4");                       // window 1: change ignored

        wait_cyc(PERIOD_CLKS + 200);
        strobes(1024);                         // capture 0x40
        push(8'h40, "R4");                     // window 2

        wait_cyc(2 * PERIOD_CLKS + 200);
        agc_level = 8'hC0;
        strobes(1023);                         // one short of refresh
        push(8'h40, "R4");                     // window 3 unchanged

        wait_cyc(3 * PERIOD_CLKS + 200);
        strobes(1);                            // 1024th strobe
        push(8'hC0, "R4");                     // window 4

        wait_cyc(4 * PERIOD_CLKS + 2000);
        use_host_duty = 1'b1;                  // mid-period mode switch
        host_duty     = 8'h00;
        push(0, "R6");                         // window 5: host duty 0

        wait_cyc(5 * PERIOD_CLKS + 300);
        host_duty = 8'hFF;
        push(255, "R3");                       // window 6: full scale

        wait_cyc(6 * PERIOD_CLKS + 300);
        use_host_duty = 1'b0;
        push(8'hC0, "R6");                     // window 7: back to loop value

        wait_cyc(7 * PERIOD_CLKS + 100);
        agc_level = 8'h01;
        strobes(1024);
        push(1, "R5");                         // window 8: applied at wrap

        wait_cyc(8 * PERIOD_CLKS + 100);
        use_host_duty = 1'b1;
        host_duty     = 8'h80;
        agc_level     = 8'h33;
        strobes(1024);                         // capture while in host mode
        push(8'h80, "R6");                     // window 9

        wait_cyc(9 * PERIOD_CLKS + 100);
        use_host_duty = 1'b0;
        push(8'h33, "R7");                     // window 10

        wait_cyc(10 * PERIOD_CLKS + 100);
        host_duty = 8'h11;                     // ignored in loop mode
        agc_level = 8'h99;                     // no strobes
        push(8'h33, "R6");                     // window 11

        wait_cyc(N_WIN * PERIOD_CLKS + 10);
        check(sb_q.size() == 0, "R3", "scoreboard drained", sb_q.size(), 0);
        report();
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, N_WIN * PERIOD_CLKS);
        report();
        $finish;
    end

endmodule